// File: doc/BRIEF.md
# Coherence Response Event Classifier

This block sits in front of a private cache's coherence controller and turns every response message arriving from the on-chip network into one controller event. A response carries a type, a signed acknowledgement count, a flag telling whether it came from a peer private cache or from the shared cache, and the current state of the line it refers to. The block keeps a small table of outstanding transactions. Each entry holds a line address and a signed pending-acknowledgement counter. The controller allocates an entry when it issues a miss and frees it when the transaction retires.

For data and acknowledgement responses, the block subtracts the carried count from the entry's pending count. A result of zero marks the response as the final one of the transaction, and the stored counter takes the new value. Exclusive data, data forwarded by a peer while a read is outstanding, and writeback acknowledgements each decode to a dedicated event. Two kinds of response raise an error and are left unconsumed: a response with an undefined type, and a response to an address with no table entry. The event and the updated counter are presented one cycle after the response is accepted.

Top module: `rsp_event_classifier`

## Requirements
- R1: After reset `evt_valid` is 0 and the table is empty, so any response raises `rsp_err`.
- R2: `alloc_ok` is high in the cycle `alloc_en` is asserted, provided a free entry exists and `alloc_addr` is not already held. The new entry's pending count is 0. A duplicate address or a full table gives `alloc_ok` = 0 and changes nothing.
- R3: Type 1 (exclusive data) always gives event code 2, whatever the counter holds. The counter is unchanged.
- R4: Type 0 (data) with `rsp_from_peer` = 1 while `rsp_line_state` is 5 (read pending) or 6 (read pending, invalidated) gives event code 3. The counter is unchanged.
- R5: Any other type-0 data sets the counter to pending minus `rsp_ack_cnt`. It gives code 1 if the result is zero and code 0 otherwise.
- R6: Type 2 (ack) sets the counter to pending minus `rsp_ack_cnt`. It gives code 5 if the result is zero and code 4 otherwise.
- R7: Type 3 (writeback ack) gives event code 6. The counter is unchanged.
- R8: Type codes 4 to 7 raise `rsp_err` with `rsp_ready` low, and no event follows.
- R9: A response whose address has no allocated entry raises `rsp_err` with `rsp_ready` low, and no event follows.
- R10: The counter is two's complement. Acknowledgements that arrive before the data drive it negative, and later messages bring it back to zero correctly.
- R11: An accepted response (`rsp_valid` and `rsp_ready`) produces `evt_valid` on the next cycle, together with the event code and the entry's count after the update. With no acceptance, `evt_valid` is 0 on the next cycle. Responses may be accepted back to back.
- R12: `free_en` releases the entry holding `free_addr`. Later responses to that address raise errors, and the slot can be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_en | input | 1 | Request to allocate a transaction entry |
| alloc_addr | input | ADDR_W | Line address of the new entry |
| alloc_ok | output | 1 | Allocation is taken this cycle |
| free_en | input | 1 | Release the entry holding `free_addr` |
| free_addr | input | ADDR_W | Line address to release |
| rsp_valid | input | 1 | A response is presented |
| rsp_ready | output | 1 | The response is consumed this cycle |
| rsp_addr | input | ADDR_W | Line address of the response |
| rsp_type | input | 3 | 0 data, 1 exclusive data, 2 ack, 3 writeback ack, 4-7 undefined |
| rsp_ack_cnt | input | ACK_W | Signed acknowledgement count carried by the response |
| rsp_from_peer | input | 1 | 1 if sent by a peer private cache, 0 if sent by the shared cache |
| rsp_line_state | input | 3 | Current line state (5 and 6 are the two read-pending states) |
| rsp_err | output | 1 | Response cannot be classified and is not consumed |
| evt_valid | output | 1 | An event is presented |
| evt_code | output | 3 | 0 data, 1 data final, 2 exclusive data, 3 peer data, 4 ack, 5 last ack, 6 writeback ack |
| evt_pending | output | CNT_W | Signed pending count after the update |

## Verification
The assertions check several relations on every cycle. Each acceptance, and only an acceptance, yields an event one cycle later, and errors are never consumed. Exclusive data and writeback acknowledgements map to fixed codes, and acknowledgements map to an ack code. Final events carry a zero count, non-final events a non-zero one, and allocation is only granted on request. Some behaviours depend on history across messages and can only be shown by the bench scenarios: the exact counter arithmetic through negative values, the peer-data split by line state, rejection of a full table or a duplicate address, and reuse of a freed slot.

// File: rtl/rsp_cls_pkg.sv
package rsp_cls_pkg;

  localparam logic [2:0] RT_DATA      = 3'd0;
  localparam logic [2:0] RT_DATA_EXCL = 3'd1;
  localparam logic [2:0] RT_ACK       = 3'd2;
  localparam logic [2:0] RT_WB_ACK    = 3'd3;

  localparam logic [2:0] LS_RD_PEND     = 3'd5;
  localparam logic [2:0] LS_RD_PEND_INV = 3'd6;

  typedef enum logic [2:0] {
    EV_DATA      = 3'd0,
    EV_DATA_ALL  = 3'd1,
    EV_DATA_EXCL = 3'd2,
    EV_PEER_DATA = 3'd3,
    EV_ACK       = 3'd4,
    EV_ACK_LAST  = 3'd5,
    EV_WB_ACK    = 3'd6
  } evt_e;

endpackage

// File: rtl/rsp_txn_table.sv
module rsp_txn_table #(
  parameter int N      = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_en,
  input  logic [ADDR_W-1:0]        alloc_addr,
  output logic                     alloc_ok,
  input  logic                     free_en,
  input  logic [ADDR_W-1:0]        free_addr,
  input  logic [ADDR_W-1:0]        look_addr,
  output logic                     look_hit,
  output logic signed [CNT_W-1:0]  look_cnt,
  input  logic                     upd_en,
  input  logic signed [CNT_W-1:0]  upd_cnt
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]              vld_q, vld_d;
  logic [ADDR_W-1:0]         tag_q [N];
  logic [ADDR_W-1:0]         tag_d [N];
  logic signed [CNT_W-1:0]   cnt_q [N];
  logic signed [CNT_W-1:0]   cnt_d [N];
  logic [N-1:0]              ent_we;
  logic [N-1:0]              m_look, m_alloc, m_free;
  logic                      slot_found;
  logic [IDX_W-1:0]          slot_idx;

  // address match per entry for the three lookup ports
  for (genvar i = 0; i < N; i++) begin : g_match
    assign m_look[i]  = vld_q[i] && (tag_q[i] == look_addr);
    assign m_alloc[i] = vld_q[i] && (tag_q[i] == alloc_addr);
    assign m_free[i]  = vld_q[i] && (tag_q[i] == free_addr);
  end

  // lowest free slot
  always_comb begin
    slot_found = 1'b0;
    slot_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        slot_found = 1'b1;
        slot_idx   = IDX_W'(i);
      end
    end
  end

  assign alloc_ok = alloc_en && slot_found && !(|m_alloc);
  assign look_hit = |m_look;

  always_comb begin
    look_cnt = '0;
    for (int i = 0; i < N; i++) begin
      if (m_look[i]) look_cnt = look_cnt | cnt_q[i];
    end
  end

  // next state: update, then release, then allocation into a free slot
  always_comb begin
    for (int i = 0; i < N; i++) begin
      vld_d[i]  = vld_q[i];
      tag_d[i]  = tag_q[i];
      cnt_d[i]  = cnt_q[i];
      ent_we[i] = 1'b0;
      if (upd_en && m_look[i]) begin
        cnt_d[i]  = upd_cnt;
        ent_we[i] = 1'b1;
      end
      if (free_en && m_free[i]) begin
        vld_d[i] = 1'b0;
      end
      if (alloc_ok && (slot_idx == IDX_W'(i))) begin
        vld_d[i]  = 1'b1;
        tag_d[i]  = alloc_addr;
        cnt_d[i]  = '0;
        ent_we[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (ent_we[i]) begin
        tag_q[i] <= tag_d[i];
        cnt_q[i] <= cnt_d[i];
      end
    end
  end

endmodule

// File: rtl/rsp_event_decode.sv
module rsp_event_decode
  import rsp_cls_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int ACK_W = 4
) (
  input  logic [2:0]               rtype,
  input  logic                     from_peer,
  input  logic [2:0]               lstate,
  input  logic signed [CNT_W-1:0]  pend,
  input  logic signed [ACK_W-1:0]  ack,
  output logic                     legal,
  output evt_e                     evt,
  output logic                     upd,
  output logic signed [CNT_W-1:0]  new_cnt
);
  logic signed [CNT_W-1:0] ack_x;
  logic signed [CNT_W-1:0] diff;
  logic                    rd_pend;

  assign ack_x   = CNT_W'(ack);
  assign diff    = pend - ack_x;
  assign rd_pend = (lstate == LS_RD_PEND) || (lstate == LS_RD_PEND_INV);

  always_comb begin
    legal   = 1'b1;
    upd     = 1'b0;
    new_cnt = pend;
    evt     = EV_DATA;
    case (rtype)
      RT_DATA_EXCL: evt = EV_DATA_EXCL;
      RT_DATA: begin
        if (from_peer && rd_pend) begin
          evt = EV_PEER_DATA;
        end else begin
          upd     = 1'b1;
          new_cnt = diff;
          evt     = (diff == '0) ? EV_DATA_ALL : EV_DATA;
        end
      end
      RT_ACK: begin
        upd     = 1'b1;
        new_cnt = diff;
        evt     = (diff == '0) ? EV_ACK_LAST : EV_ACK;
      end
      RT_WB_ACK: evt = EV_WB_ACK;
      default:   legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/rsp_event_classifier.sv
module rsp_event_classifier
  import rsp_cls_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 6,
  parameter int ACK_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_en,
  input  logic [ADDR_W-1:0]        alloc_addr,
  output logic                     alloc_ok,
  input  logic                     free_en,
  input  logic [ADDR_W-1:0]        free_addr,
  input  logic                     rsp_valid,
  output logic                     rsp_ready,
  input  logic [ADDR_W-1:0]        rsp_addr,
  input  logic [2:0]               rsp_type,
  input  logic signed [ACK_W-1:0]  rsp_ack_cnt,
  input  logic                     rsp_from_peer,
  input  logic [2:0]               rsp_line_state,
  output logic                     rsp_err,
  output logic                     evt_valid,
  output logic [2:0]               evt_code,
  output logic signed [CNT_W-1:0]  evt_pending
);
  logic                    hit;
  logic signed [CNT_W-1:0] cur_cnt;
  logic                    legal;
  evt_e                    dec_evt;
  logic                    dec_upd;
  logic signed [CNT_W-1:0] dec_cnt;
  logic                    accept;

  logic                    ev_vld_q, ev_vld_d;
  evt_e                    ev_code_q, ev_code_d;
  logic signed [CNT_W-1:0] ev_cnt_q, ev_cnt_d;

  rsp_txn_table #(.N(N), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_en),
    .alloc_addr (alloc_addr),
    .alloc_ok   (alloc_ok),
    .free_en    (free_en),
    .free_addr  (free_addr),
    .look_addr  (rsp_addr),
    .look_hit   (hit),
    .look_cnt   (cur_cnt),
    .upd_en     (accept && dec_upd),
    .upd_cnt    (dec_cnt)
  );

  rsp_event_decode #(.CNT_W(CNT_W), .ACK_W(ACK_W)) u_dec (
    .rtype     (rsp_type),
    .from_peer (rsp_from_peer),
    .lstate    (rsp_line_state),
    .pend      (cur_cnt),
    .ack       (rsp_ack_cnt),
    .legal     (legal),
    .evt       (dec_evt),
    .upd       (dec_upd),
    .new_cnt   (dec_cnt)
  );

  assign accept    = rsp_valid && hit && legal;
  assign rsp_ready = accept;
  assign rsp_err   = rsp_valid && !(hit && legal);

  always_comb begin
    ev_vld_d  = accept;
    ev_code_d = ev_code_q;
    ev_cnt_d  = ev_cnt_q;
    if (accept) begin
      ev_code_d = dec_evt;
      ev_cnt_d  = dec_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_vld_q  <= 1'b0;
      ev_code_q <= EV_DATA;
      ev_cnt_q  <= '0;
    end else begin
      ev_vld_q  <= ev_vld_d;
      ev_code_q <= ev_code_d;
      ev_cnt_q  <= ev_cnt_d;
    end
  end

  assign evt_valid   = ev_vld_q;
  assign evt_code    = ev_code_q;
  assign evt_pending = ev_cnt_q;

endmodule

// File: rtl/rsp_event_classifier_chk.sv
module rsp_event_classifier_chk
  import rsp_cls_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    alloc_en,
  input logic                    alloc_ok,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [2:0]              rsp_type,
  input logic                    rsp_err,
  input logic                    evt_valid,
  input logic [2:0]              evt_code,
  input logic signed [CNT_W-1:0] evt_pending
);
  logic acc;
  assign acc = rsp_valid && rsp_ready;

  p_evt_follows_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> evt_valid);
  p_no_spurious_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !evt_valid);
  p_err_not_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !rsp_ready);
  p_bad_type_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_type > 3'd3) |-> rsp_err);
  p_excl_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rsp_type == RT_DATA_EXCL) |=> (evt_code == EV_DATA_EXCL));
  p_wb_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rsp_type == RT_WB_ACK) |=> (evt_code == EV_WB_ACK));
  p_ack_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rsp_type == RT_ACK) |=> (evt_code == EV_ACK || evt_code == EV_ACK_LAST));
  p_final_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_code == EV_DATA_ALL || evt_code == EV_ACK_LAST)) |-> (evt_pending == '0));
  p_nonfinal_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_code == EV_DATA || evt_code == EV_ACK)) |-> (evt_pending != '0));
  p_alloc_on_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> alloc_en);

endmodule

bind rsp_event_classifier rsp_event_classifier_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_rsp_event_classifier.sv
module tb_rsp_event_classifier;
  localparam int N      = 4;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 6;
  localparam int ACK_W  = 4;

  logic                    clk;
  logic                    rst_n;
  logic                    alloc_en;
  logic [ADDR_W-1:0]       alloc_addr;
  logic                    alloc_ok;
  logic                    free_en;
  logic [ADDR_W-1:0]       free_addr;
  logic                    rsp_valid;
  logic                    rsp_ready;
  logic [ADDR_W-1:0]       rsp_addr;
  logic [2:0]              rsp_type;
  logic signed [ACK_W-1:0] rsp_ack_cnt;
  logic                    rsp_from_peer;
  logic [2:0]              rsp_line_state;
  logic                    rsp_err;
  logic                    evt_valid;
  logic [2:0]              evt_code;
  logic signed [CNT_W-1:0] evt_pending;

  rsp_event_classifier #(.N(N), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ACK_W(ACK_W)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int pend [int];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int code);
    case (code)
      0, 1: return "R5";
      2: return "R3";
      3: return "R4";
      4, 5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic idle_inputs();
    alloc_en = 0; alloc_addr = '0; free_en = 0; free_addr = '0;
    rsp_valid = 0; rsp_addr = '0; rsp_type = '0; rsp_ack_cnt = '0;
    rsp_from_peer = 0; rsp_line_state = '0;
  endtask

  // one clock: predict, compare combinational outputs, advance model, compare event
  task automatic tick();
    bit hit, legal, acc, aok, upd;
    int e, np, cur, d, ak;
    string tg;
    #1;
    hit   = rsp_valid && pend.exists(int'(rsp_addr));
    legal = rsp_type < 3'd4;
    acc   = hit && legal;
    tg    = !rsp_valid ? "R11" : (!legal ? "R8" : (!hit ? "R9" : "R11"));
    chk(rsp_ready === acc, tg, "rsp_ready", int'(rsp_ready), int'(acc));
    chk(rsp_err === (rsp_valid && !acc), tg, "rsp_err", int'(rsp_err), int'(rsp_valid && !acc));
    aok = alloc_en && !pend.exists(int'(alloc_addr)) && (pend.num() < N);
    chk(alloc_ok === aok, "R2", "alloc_ok", int'(alloc_ok), int'(aok));
    e = 0; np = 0; upd = 0;
    if (acc) begin
      cur = pend[int'(rsp_addr)];
      ak  = int'(rsp_ack_cnt);
      d   = cur - ak;
      np  = cur;
      case (rsp_type)
        3'd1: e = 2;
        3'd0: if (rsp_from_peer && (rsp_line_state == 3'd5 || rsp_line_state == 3'd6)) e = 3;
              else begin upd = 1; np = d; e = (d == 0) ? 1 : 0; end
        3'd2: begin upd = 1; np = d; e = (d == 0) ? 5 : 4; end
        default: e = 6;
      endcase
    end
    @(posedge clk);
    if (acc && upd) pend[int'(rsp_addr)] = np;
    if (free_en && pend.exists(int'(free_addr))) pend.delete(int'(free_addr));
    if (aok) pend[int'(alloc_addr)] = 0;
    @(negedge clk);
    chk(evt_valid === acc, "R11", "evt_valid", int'(evt_valid), int'(acc));
    if (acc) begin
      chk(int'(evt_code) == e, tag_of(e), "evt_code", int'(evt_code), e);
      chk(int'(evt_pending) == np, (np < 0) ? "R10" : tag_of(e), "evt_pending", int'(evt_pending), np);
    end
  endtask

  task automatic do_alloc(input int a);
    alloc_en = 1; alloc_addr = ADDR_W'(a); tick(); idle_inputs();
  endtask

  task automatic do_free(input int a);
    free_en = 1; free_addr = ADDR_W'(a); tick(); idle_inputs();
  endtask

  task automatic send(input int a, input int t, input int ack, input bit peer, input int ls);
    rsp_valid = 1; rsp_addr = ADDR_W'(a); rsp_type = 3'(t);
    rsp_ack_cnt = ACK_W'(ack); rsp_from_peer = peer; rsp_line_state = 3'(ls);
    tick(); idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(evt_valid === 1'b0, "R1", "evt_valid in reset", int'(evt_valid), 0);
    rst_n = 1;
    tick();
    chk(evt_valid === 1'b0, "R1", "evt_valid after reset", int'(evt_valid), 0);
    // R1/R9: empty table rejects responses
    send(16'h0010, 0, 0, 0, 0);
    send(16'h0100, 2, 1, 0, 0);

    // R2: allocation and duplicate rejection
    do_alloc(16'h0100);
    do_alloc(16'h0100);

    // R10 and R6: early acks drive the counter negative
    send(16'h0100, 2, 1, 0, 2);
    send(16'h0100, 2, 1, 0, 2);
    // R5: data with count -3 -> pending 1, non-final
    send(16'h0100, 0, -3, 0, 2);
    // R6: last ack
    send(16'h0100, 2, 1, 0, 2);

    // R12: release and check errors after
    do_free(16'h0100);
    send(16'h0100, 2, 1, 0, 2);

    // R5: data with zero count is final at once
    do_alloc(16'h0200);
    send(16'h0200, 0, 0, 0, 5);
    // R3: exclusive data ignores count
    send(16'h0200, 1, 3, 0, 5);
    send(16'h0200, 1, -2, 1, 1);
    // R4: peer data in the read-pending states
    send(16'h0200, 0, 2, 1, 5);
    send(16'h0200, 0, 2, 1, 6);
    // R4 boundary: peer data in another state and shared-cache data in state 5 use the count
    send(16'h0200, 0, 2, 1, 1);
    send(16'h0200, 0, -2, 0, 5);
    // R7: writeback ack
    send(16'h0200, 3, 0, 0, 7);
    // R8: undefined types
    send(16'h0200, 4, 0, 0, 0);
    send(16'h0200, 7, 1, 0, 0);

    // R2: fill table, overflow rejected
    do_alloc(16'h0301);
    do_alloc(16'h0302);
    do_alloc(16'h0303);
    do_alloc(16'h0304);
    // R12: free one, slot reused
    do_free(16'h0302);
    do_alloc(16'h0304);
    send(16'h0304, 2, -1, 0, 0);

    // R11: back-to-back responses on different entries with concurrent free/alloc
    rsp_valid = 1; rsp_addr = 16'h0301; rsp_type = 3'd2; rsp_ack_cnt = 4'sd1;
    tick();
    rsp_addr = 16'h0303; rsp_type = 3'd0; rsp_ack_cnt = -4'sd1; free_en = 1; free_addr = 16'h0200;
    tick();
    rsp_addr = 16'h0301; rsp_type = 3'd0; rsp_ack_cnt = -4'sd1; free_en = 0;
    alloc_en = 1; alloc_addr = 16'h0400;
    tick();
    idle_inputs();
    send(16'h0400, 2, 1, 0, 0);
    send(16'h0400, 2, -1, 0, 0);
    tick();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule